// File: doc/BRIEF.md
# Two-Port Semaphore Token Unit

This block holds eight token flags that two independent ports share to reserve common resources. The flags are kept apart from any data memory. Each port has a select, a write strobe, a read strobe, an address, a one-bit write value and a read bus. A port asks for a token by writing 0 to it and gives it up by writing 1. It finds out whether it holds the token by reading it back.

Each port sees its own view of a token. A port that asks for a token while the other side holds it keeps its request on file. It receives the token on the same clock edge on which the holder gives it up. Read data is captured into a register on the port. The value a port has read therefore stays steady while the other side writes.

All actions take effect on the rising clock edge. A read captures the state as it stood before any write made on that same edge.

Top module: `semtok_unit`

## Requirements
- R1: The token index is address bits [2:0], so eight tokens are addressed. Address bits above bit 2 have no effect on which token is accessed.
- R2: A port acts only when its select is high. With the select low, its write and read strobes change no token state, and its read bus holds its previous value.
- R3: A write with write value 0 is a request for the token. A write with write value 1 is a release, or the withdrawal of a request.
- R4: A token that nobody holds reads as 1 on both ports. A held token reads 0 on the holder's port and 1 on the other port. A read loads the read bus on the clock edge where select and read strobe are both high. The value loaded is the state before any write applied on that edge, including a write from the same port.
- R5: While a token is held, a request from the other port does not change what either port reads. The request is recorded as pending.
- R6: When the holder releases a token, ownership moves on that edge to the other port if that port has a pending request or requests on that same edge. Otherwise the token becomes free.
- R7: A release written by the port that does not hold the token withdraws only that port's pending request. The holder keeps the token.
- R8: If both ports request the same free token on the same edge, the left port obtains it. The right port's request stays pending.
- R9: Every bit of a port's read bus carries the token value that was read.
- R10: The read bus keeps its value until that port's next read. Writes from the other port do not change it.
- R11: After reset every token is free, no request is pending, and both read buses are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lSel | input | 1 | Left port select |
| lWrEn | input | 1 | Left write strobe |
| lRdEn | input | 1 | Left read strobe |
| lAddr | input | ADDR_W | Left address; only bits [2:0] are used |
| lWrBit | input | 1 | Left write value (0 request, 1 release) |
| lRdData | output | DATA_W | Left read bus, token value replicated |
| rSel | input | 1 | Right port select |
| rWrEn | input | 1 | Right write strobe |
| rRdEn | input | 1 | Right read strobe |
| rAddr | input | ADDR_W | Right address; only bits [2:0] are used |
| rWrBit | input | 1 | Right write value (0 request, 1 release) |
| rRdData | output | DATA_W | Right read bus, token value replicated |

## Verification
The internal state of a token is an owner plus two pending flags. It is visible only through reads. A wrong owner shows up as a wrong read value on the edge of the next read of that token. A wrong pending flag stays hidden until the holder releases the token: the token then goes to the wrong side, or frees when it should pass on. That error appears on the first read after the release. The bench therefore reads tokens back after every ownership change, and its reference model compares both read buses on every clock. A stale pending flag is thus caught within one read of the release that exposes it.

// File: rtl/semtok_pkg.sv
package semtok_pkg;
  localparam int SEM_COUNT = 8;
  localparam int SEM_IDX_W = $clog2(SEM_COUNT);

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Strobes from the port decoder to the token datapath
  typedef struct packed {
    logic [SEM_COUNT-1:0] reqL;
    logic [SEM_COUNT-1:0] relL;
    logic [SEM_COUNT-1:0] reqR;
    logic [SEM_COUNT-1:0] relR;
    logic                 capL;
    logic                 capR;
    logic [SEM_IDX_W-1:0] idxL;
    logic [SEM_IDX_W-1:0] idxR;
  } semStrobe_t;
endpackage

// File: rtl/semtok_ctrl.sv
module semtok_ctrl
  import semtok_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              lSel,
  input  logic              lWrEn,
  input  logic              lRdEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrBit,
  input  logic              rSel,
  input  logic              rWrEn,
  input  logic              rRdEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrBit,
  output semStrobe_t        strb
);
  logic [SEM_IDX_W-1:0] idxL;
  logic [SEM_IDX_W-1:0] idxR;
  logic                 wrL;
  logic                 wrR;
  logic [SEM_COUNT-1:0] hitL;
  logic [SEM_COUNT-1:0] hitR;

  // R1: only the low index bits select a token
  assign idxL = lAddr[SEM_IDX_W-1:0];
  assign idxR = rAddr[SEM_IDX_W-1:0];
  // R2: select gates every strobe
  assign wrL  = lSel & lWrEn;
  assign wrR  = rSel & rWrEn;

  for (genvar s = 0; s < SEM_COUNT; s++) begin : g_dec
    assign hitL[s] = (idxL == SEM_IDX_W'(s));
    assign hitR[s] = (idxR == SEM_IDX_W'(s));
  end

  // R3: write value 0 requests, 1 releases
  always_comb begin
    strb      = '0;
    strb.reqL = (wrL && !lWrBit) ? hitL : '0;
    strb.relL = (wrL &&  lWrBit) ? hitL : '0;
    strb.reqR = (wrR && !rWrBit) ? hitR : '0;
    strb.relR = (wrR &&  rWrBit) ? hitR : '0;
    strb.capL = lSel & lRdEn;
    strb.capR = rSel & rRdEn;
    strb.idxL = idxL;
    strb.idxR = idxR;
  end
endmodule

// File: rtl/semtok_cell.sv
module semtok_cell
  import semtok_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reqL,
  input  logic relL,
  input  logic reqR,
  input  logic relR,
  output logic viewL,
  output logic viewR
);
  owner_e ownerQ, ownerD;
  logic   pendLQ, pendLD;
  logic   pendRQ, pendRD;
  logic   effL, effR;

  always_comb begin
    effL   = (pendLQ | reqL) & ~relL;
    effR   = (pendRQ | reqR) & ~relR;
    ownerD = ownerQ;
    pendLD = pendLQ;
    pendRD = pendRQ;
    case (ownerQ)
      OWN_NONE: begin
        pendLD = 1'b0;
        pendRD = 1'b0;
        if (reqL) begin
          ownerD = OWN_LEFT;   // R8: left wins a tie
          pendRD = reqR;
        end else if (reqR) begin
          ownerD = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        pendLD = 1'b0;
        if (relL) begin
          ownerD = effR ? OWN_RIGHT : OWN_NONE;
          pendRD = 1'b0;
        end else begin
          pendRD = effR;
        end
      end
      OWN_RIGHT: begin
        pendRD = 1'b0;
        if (relR) begin
          ownerD = effL ? OWN_LEFT : OWN_NONE;
          pendLD = 1'b0;
        end else begin
          pendLD = effL;
        end
      end
      default: begin
        ownerD = OWN_NONE;
        pendLD = 1'b0;
        pendRD = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ownerQ <= OWN_NONE;
      pendLQ <= 1'b0;
      pendRQ <= 1'b0;
    end else begin
      ownerQ <= ownerD;
      pendLQ <= pendLD;
      pendRQ <= pendRD;
    end
  end

  assign viewL = (ownerQ != OWN_LEFT);
  assign viewR = (ownerQ != OWN_RIGHT);

  // R5
  heldLeft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownerQ == OWN_LEFT && !relL) |=> ownerQ == OWN_LEFT);
  // R5
  heldRight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownerQ == OWN_RIGHT && !relR) |=> ownerQ == OWN_RIGHT);
  // R6
  freeOnRelease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownerQ == OWN_LEFT && relL && !pendRQ && !reqR) |=> ownerQ == OWN_NONE);
  // R6
  handLeftToRight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownerQ == OWN_LEFT && relL && pendRQ && !relR) |=> ownerQ == OWN_RIGHT);
  // R8
  tieToLeft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownerQ == OWN_NONE && reqL && reqR) |=> (ownerQ == OWN_LEFT && pendRQ));
endmodule

// File: rtl/semtok_datapath.sv
module semtok_datapath
  import semtok_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  semStrobe_t        strb,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData
);
  logic [SEM_COUNT-1:0] viewL;
  logic [SEM_COUNT-1:0] viewR;

  for (genvar s = 0; s < SEM_COUNT; s++) begin : g_cell
    semtok_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .reqL  (strb.reqL[s]),
      .relL  (strb.relL[s]),
      .reqR  (strb.reqR[s]),
      .relR  (strb.relR[s]),
      .viewL (viewL[s]),
      .viewR (viewR[s])
    );
  end

  // R4, R9, R10: capture the pre-write view, replicated over the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lRdData <= '1;
      rRdData <= '1;
    end else begin
      if (strb.capL) lRdData <= {DATA_W{viewL[strb.idxL]}};
      if (strb.capR) rRdData <= {DATA_W{viewR[strb.idxR]}};
    end
  end

  // R10
  holdLeft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capL |=> $stable(lRdData));
  // R10
  holdRight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capR |=> $stable(rRdData));
  // R9
  wideLeft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lRdData == '0) || (lRdData == '1));
  // R9
  wideRight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rRdData == '0) || (rRdData == '1));
  // R4
  notBothZero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capL && strb.capR && strb.idxL == strb.idxR) |=> (lRdData[0] | rRdData[0]));
endmodule

// File: rtl/semtok_unit.sv
module semtok_unit
  import semtok_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lSel,
  input  logic              lWrEn,
  input  logic              lRdEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrBit,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rSel,
  input  logic              rWrEn,
  input  logic              rRdEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrBit,
  output logic [DATA_W-1:0] rRdData
);
  semStrobe_t strb;

  semtok_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .lSel   (lSel),
    .lWrEn  (lWrEn),
    .lRdEn  (lRdEn),
    .lAddr  (lAddr),
    .lWrBit (lWrBit),
    .rSel   (rSel),
    .rWrEn  (rWrEn),
    .rRdEn  (rRdEn),
    .rAddr  (rAddr),
    .rWrBit (rWrBit),
    .strb   (strb)
  );

  semtok_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .lRdData (lRdData),
    .rRdData (rRdData)
  );
endmodule

// File: tb/tb_semtok_unit.sv
module tb_semtok_unit;
  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 16;
  localparam int PERIOD   = 10;
  localparam int WD_LIMIT = 50000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lSel = 0, lWrEn = 0, lRdEn = 0, lWrBit = 0;
  logic              rSel = 0, rWrEn = 0, rRdEn = 0, rWrBit = 0;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic [DATA_W-1:0] lRdData, rRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference: 0 free, 1 left holds, 2 right holds
  int          own[8];
  bit          pendL[8];
  bit          pendR[8];
  logic [DATA_W-1:0] expL = '1;
  logic [DATA_W-1:0] expR = '1;

  always #(PERIOD/2) clk = ~clk;

  semtok_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lSel(lSel), .lWrEn(lWrEn), .lRdEn(lRdEn), .lAddr(lAddr), .lWrBit(lWrBit), .lRdData(lRdData),
    .rSel(rSel), .rWrEn(rWrEn), .rRdEn(rRdEn), .rAddr(rAddr), .rWrBit(rWrBit), .rRdData(rRdData)
  );

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input bit wl, input bit rl, input int il, input bit bl,
                       input bit wr, input bit rr, input int ir, input bit br);
    // reads see the state before this edge's writes
    if (rl) expL = (own[il] == 1) ? '0 : '1;
    if (rr) expR = (own[ir] == 2) ? '0 : '1;
    for (int s = 0; s < 8; s++) begin
      bit aL = wl && (il == s);
      bit aR = wr && (ir == s);
      case (own[s])
        0: begin
          if (aL && !bl) begin own[s] = 1; pendR[s] = aR && !br; end
          else if (aR && !br) own[s] = 2;
        end
        1: begin
          if (aL && bl) begin
            if ((pendR[s] || (aR && !br)) && !(aR && br)) own[s] = 2; else own[s] = 0;
            pendR[s] = 0;
          end else if (aR) pendR[s] = !br;
        end
        default: begin
          if (aR && br) begin
            if ((pendL[s] || (aL && !bl)) && !(aL && bl)) own[s] = 1; else own[s] = 0;
            pendL[s] = 0;
          end else if (aL) pendL[s] = !bl;
        end
      endcase
    end
  endtask

  task automatic cyc(input logic lS, input logic lW, input logic lR, input logic [ADDR_W-1:0] lA, input logic lB,
                     input logic rS, input logic rW, input logic rR, input logic [ADDR_W-1:0] rA, input logic rB,
                     input string tag);
    lSel = lS; lWrEn = lW; lRdEn = lR; lAddr = lA; lWrBit = lB;
    rSel = rS; rWrEn = rW; rRdEn = rR; rAddr = rA; rWrBit = rB;
    @(posedge clk);
    model(lS && lW, lS && lR, int'(lA[2:0]), lB, rS && rW, rS && rR, int'(rA[2:0]), rB);
    @(negedge clk);
    check(lRdData, expL, {tag, " left"});
    check(rRdData, expR, {tag, " right"});
  endtask

  task automatic lWr(input logic [ADDR_W-1:0] a, input logic b, input string tag);
    cyc(1, 1, 0, a, b, 0, 0, 0, '0, 0, tag);
  endtask
  task automatic rWr(input logic [ADDR_W-1:0] a, input logic b, input string tag);
    cyc(0, 0, 0, '0, 0, 1, 1, 0, a, b, tag);
  endtask
  task automatic rdBoth(input logic [ADDR_W-1:0] la, input logic [ADDR_W-1:0] ra, input string tag);
    cyc(1, 0, 1, la, 0, 1, 0, 1, ra, 0, tag);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin own[s] = 0; pendL[s] = 0; pendR[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(lRdData, '1, "R11 reset left");
    check(rRdData, '1, "R11 reset right");
    for (int s = 0; s < 8; s++) rdBoth(ADDR_W'(s), ADDR_W'(s), "R11 R4 free after reset");

    lWr(13'h1FFA, 0, "R3 R1 left request token 2");
    rdBoth(13'h0002, 13'h155A, "R4 R1 owner view");
    check(lRdData, '0, "R4 left holder reads 0");
    check(rRdData, '1, "R4 right other reads 1");
    rWr(13'h0002, 0, "R5 right request while held");
    rdBoth(13'h0002, 13'h0002, "R5 views unchanged");
    lWr(13'h0002, 1, "R6 left release with pending");
    rdBoth(13'h0002, 13'h0002, "R6 handed to right");
    check(rRdData, '0, "R6 right now holds");
    lWr(13'h0002, 0, "R5 left request while right holds");
    rWr(13'h0002, 1, "R6 right release");
    rdBoth(13'h0002, 13'h0002, "R6 handed to left");
    lWr(13'h0002, 1, "R6 release no pending");
    rdBoth(13'h0002, 13'h0002, "R6 token free");

    rWr(13'h0005, 0, "R3 right request 5");
    lWr(13'h0005, 0, "R5 left pending 5");
    lWr(13'h0005, 1, "R7 left withdraws");
    rdBoth(13'h0005, 13'h0005, "R7 right still holds");
    rWr(13'h0005, 1, "R7 release after withdraw");
    rdBoth(13'h0005, 13'h0005, "R7 token free");

    cyc(1, 1, 0, 13'h0007, 0, 1, 1, 0, 13'h0FFF, 0, "R8 tie request");
    rdBoth(13'h0007, 13'h0007, "R8 left wins");
    check(lRdData, '0, "R8 left holds");
    lWr(13'h0007, 1, "R8 release");
    rdBoth(13'h0007, 13'h0007, "R8 right pending granted");
    check(rRdData, '0, "R8 right holds");
    rWr(13'h0007, 1, "R8 right release");

    cyc(0, 1, 0, 13'h0000, 0, 0, 0, 0, '0, 0, "R2 deselected write");
    lWr(13'h0006, 0, "R2 set left bus source");
    cyc(1, 0, 1, 13'h0006, 0, 0, 0, 0, '0, 0, "R2 left reads 0");
    cyc(0, 0, 1, 13'h0000, 0, 0, 0, 1, 13'h0000, 0, "R2 deselected read holds");
    check(lRdData, '0, "R2 bus held");
    rdBoth(13'h0000, 13'h0000, "R2 token 0 still free");
    lWr(13'h0006, 1, "R3 release 6");

    cyc(1, 0, 1, 13'h0003, 0, 0, 0, 0, '0, 0, "R10 left reads 3");
    rWr(13'h0003, 0, "R10 right takes 3");
    check(lRdData, '1, "R10 left bus unchanged");
    rWr(13'h0003, 1, "R10 right releases 3");

    cyc(1, 1, 1, 13'h0004, 0, 0, 0, 0, '0, 0, "R4 write and read same edge");
    check(lRdData, '1, "R4 pre-write value captured");
    cyc(1, 0, 1, 13'h0004, 0, 0, 0, 0, '0, 0, "R4 later read");
    check(lRdData, '0, "R4 now holder");
    lWr(13'h0004, 1, "R3 release 4");

    lWr(13'h0006, 0, "R6 left takes 6");
    cyc(1, 1, 0, 13'h0006, 1, 1, 1, 0, 13'h0006, 0, "R6 release with same-edge request");
    rdBoth(13'h0006, 13'h0006, "R6 right granted same edge");
    check(rRdData, '0, "R6 right holds 6");

    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] la = ADDR_W'($urandom);
      logic [ADDR_W-1:0] ra = ADDR_W'($urandom);
      if ($urandom_range(0, 1) == 1) ra[2:0] = la[2:0];
      cyc($urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom), la, 1'($urandom),
          $urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom), ra, 1'($urandom),
          "R9 R1 random traffic");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule